// File: doc/BRIEF.md
# Embedded RAM/FIFO Self-Test Engine with Triple CRC Signatures

This engine sits beside one embedded RAM block and checks the block's address counters and storage without software involvement. A two-bit test mode is loaded bit by bit through a serial control input. A start pulse then launches a sweep. The engine steps through every supported depth configuration, from 128 words up to 4096 words. For each depth it drives the write counter over the full address range and writes a mode-dependent data pattern, then drives the read counter over the same range and reads the words back.

Three independent 16-bit CRC registers compress the activity during the sweep. One takes the write-counter outputs, one takes the read-counter outputs, and one takes the data read from the array. When the sweep ends, the 48 signature bits are offered on a one-bit valid/ready stream so that they can be compared with a precomputed value. The stream holds its bit while ready is low and moves on only when a bit is accepted. The start input can be wired to many engines at once so that they all run in lockstep.

Top module: `mbist_engine`

## Requirements
- R1: After reset, busy and sig_valid are low.
- R2: While busy is low and ctl_shift_en is high, ctl_sdi is shifted in on every clock, and the mode is the last two bits shifted in, with the earlier of the two becoming bit 0. The pattern written at address a is as follows. Mode 0 writes a[7:0]. Mode 1 writes ~a[7:0]. Mode 2 writes 0x55 at even addresses and 0xAA at odd ones. Mode 3 writes {a[3:0], a[7:4]}.
- R3: A start sampled high while idle makes busy high from the next cycle. The sweep covers depths 128, 256, 512, 1024, 2048 and 4096 in that order. Each depth writes addresses 0 to depth-1 and then reads the same addresses. Busy then stays high for exactly 16130 cycles.
- R4: The write signature starts at 0xFFFF and takes one 16-bit word per write, shifted in MSB first through the polynomial x^16+x^12+x^5+1. Bit 15 of the word is 0, bits 14:12 hold the depth index (0 for 128, up to 5 for 4096), and bits 11:0 hold the address.
- R5: The read signature uses the same rule, taking one word per read with bit 15 set to 1.
- R6: The data signature uses the same rule, taking one word {8'h00, read data} for each word read.
- R7: A start pulse or serial shifting while busy is high has no effect on the run in progress or on the mode used by the next run.
- R8: Signature bits are offered only while busy is low. Once a run ends, sig_valid is high for 48 accepted bits: the write signature, then the read signature, then the data signature, each sent LSB first. A bit advances only when sig_valid and sig_ready are both high, it holds while sig_ready is low, and sig_valid falls after the 48th bit is accepted.
- R9: Engines that share one start pulse raise and drop busy on the same cycles.
- R10: A start accepted while bits are still being offered discards the rest of the signature, so sig_valid is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_shift_en | input | 1 | Shift ctl_sdi into the control register |
| ctl_sdi | input | 1 | Serial control data |
| start | input | 1 | Launch a sweep (ignored while busy) |
| busy | output | 1 | Sweep in progress |
| sig_valid | output | 1 | Signature stream bit valid |
| sig_ready | input | 1 | Signature stream bit accepted |
| sig_bit | output | 1 | Signature stream data |

## Verification
Assertions check several properties on every cycle. Every active address stays inside the current depth, and the depth index only ever moves up by one within a run. The mode and the run stay unaffected by start while a sweep is active. The stream never offers a bit during a run and holds its bit under back-pressure. The signature values themselves can be confirmed only by the bench scenarios, because the bench recomputes the three CRCs for each mode. The scenarios also measure the exact sweep length, the effect of shifting and starting while busy, an abandoned unload, and lockstep between two engines.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    PAT_ADDR    = 2'd0,
    PAT_INV     = 2'd1,
    PAT_CHECKER = 2'd2,
    PAT_SWAP    = 2'd3
  } pat_mode_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_WRITE = 3'd1,
    S_READ  = 3'd2,
    S_DRAIN = 3'd3,
    S_FIN   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/mbist_ctrl_port.sv
module mbist_ctrl_port
  import mbist_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      shift_en,
  input  logic      sdi,
  input  logic      busy,
  input  logic      launch,
  output pat_mode_e mode
);
  logic [MODE_W-1:0] shreg;
  pat_mode_e         mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      mode_q <= PAT_ADDR;
    end else begin
      if (shift_en && !busy) shreg <= {sdi, shreg[MODE_W-1:1]};
      if (launch) mode_q <= pat_mode_e'(shreg);
    end
  end

  assign mode = mode_q;

  // R7: mode cannot move while a sweep is running
  p_mode_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q));
endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int MIN_LOG = 7,
  parameter int MAX_LOG = 12,
  parameter int DW      = 8,
  localparam int AW     = MAX_LOG,
  localparam int NDEPTH = MAX_LOG - MIN_LOG + 1,
  localparam int KW     = (NDEPTH > 1) ? $clog2(NDEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  pat_mode_e     mode,
  output logic          busy,
  output logic          launch,
  output logic          fin,
  output logic          wen,
  output logic          ren,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic [KW-1:0] didx,
  output logic          rd_vld
);
  seq_state_e    state;
  logic [AW-1:0] cnt;
  logic [KW-1:0] k_q;
  logic [AW:0]   depth_v;
  logic [AW-1:0] last;
  logic          last_depth;

  function automatic logic [DW-1:0] pattern(pat_mode_e m, logic [AW-1:0] a);
    logic [DW-1:0] ax;
    ax = DW'(a);
    case (m)
      PAT_ADDR:    return ax;
      PAT_INV:     return ~ax;
      PAT_CHECKER: return a[0] ? {(DW/2){2'b10}} : {(DW/2){2'b01}};
      PAT_SWAP:    return {ax[DW/2-1:0], ax[DW-1:DW/2]};
      default:     return ax;
    endcase
  endfunction

  always_comb begin
    depth_v    = (AW+1)'(1) << (MIN_LOG + 32'(k_q));
    last       = AW'(depth_v - 1'b1);
    last_depth = (k_q == KW'(NDEPTH - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      k_q    <= '0;
      rd_vld <= 1'b0;
    end else begin
      rd_vld <= (state == S_READ);
      case (state)
        S_IDLE: if (start) begin
          state <= S_WRITE;
          cnt   <= '0;
          k_q   <= '0;
        end
        S_WRITE: begin
          if (cnt == last) begin
            cnt   <= '0;
            state <= S_READ;
          end else cnt <= cnt + 1'b1;
        end
        S_READ: begin
          if (cnt == last) begin
            cnt <= '0;
            if (last_depth) state <= S_DRAIN;
            else begin
              k_q   <= k_q + 1'b1;
              state <= S_WRITE;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_DRAIN: state <= S_FIN;
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy   = (state != S_IDLE);
  assign launch = (state == S_IDLE) && start;
  assign fin    = (state == S_FIN);
  assign wen    = (state == S_WRITE);
  assign ren    = (state == S_READ);
  assign addr   = cnt;
  assign wdata  = pattern(mode, cnt);
  assign didx   = k_q;

  // R3: counters stay inside the active depth configuration
  p_addr_in_depth_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wen || ren) |-> (addr <= last));
  // R3: depths are visited shallow to deep, one step at a time
  p_depth_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && !$stable(k_q)) |-> (k_q == $past(k_q) + 1'b1));
  // R7: a start during an active sweep does not end it
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin && start) |=> busy);
endmodule

// File: rtl/mbist_ram.sv
module mbist_ram #(
  parameter int AW = 12,
  parameter int DW = 8,
  localparam int WORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          ren,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wen) mem[waddr] <= wdata;
    if (ren) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mbist_crc.sv
module mbist_crc #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021,
  parameter logic [W-1:0] SEED = 16'hFFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed_en,
  input  logic         upd_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig
);
  function automatic logic [W-1:0] step(logic [W-1:0] c, logic [W-1:0] d);
    logic [W-1:0] r;
    logic         fb;
    r = c;
    for (int i = W - 1; i >= 0; i--) begin
      fb = r[W-1] ^ d[i];
      r  = {r[W-2:0], 1'b0};
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       sig <= SEED;
    else if (seed_en) sig <= SEED;
    else if (upd_en)  sig <= step(sig, din);
  end
endmodule

// File: rtl/mbist_sig_out.sv
module mbist_sig_out #(
  parameter int TOTAL = 48,
  localparam int CNW  = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clear,
  input  logic [TOTAL-1:0] sig_flat,
  input  logic             ready,
  output logic             valid,
  output logic             bit_o
);
  logic [TOTAL-1:0] sh;
  logic [CNW-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (load) begin
      sh  <= sig_flat;
      cnt <= CNW'(TOTAL);
    end else if (valid && ready) begin
      sh  <= {1'b0, sh[TOTAL-1:1]};
      cnt <= cnt - 1'b1;
    end
  end

  assign valid = (cnt != '0);
  assign bit_o = sh[0];

  // R8: back-pressure holds the offered bit
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !clear) |=> (valid && $stable(bit_o)));
endmodule

// File: rtl/mbist_engine.sv
module mbist_engine
  import mbist_pkg::*;
#(
  parameter int          MIN_LOG = 7,
  parameter int          MAX_LOG = 12,
  parameter int          DW      = 8,
  parameter int          CW      = 16,
  parameter logic [15:0] POLY    = 16'h1021,
  parameter logic [15:0] SEED    = 16'hFFFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_shift_en,
  input  logic ctl_sdi,
  input  logic start,
  output logic busy,
  output logic sig_valid,
  input  logic sig_ready,
  output logic sig_bit
);
  localparam int AW     = MAX_LOG;
  localparam int NDEPTH = MAX_LOG - MIN_LOG + 1;
  localparam int KW     = (NDEPTH > 1) ? $clog2(NDEPTH) : 1;
  localparam int NSIG   = 3;
  localparam int TOTAL  = NSIG * CW;

  pat_mode_e     mode;
  logic          launch, fin, wen, ren, rd_vld;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic [KW-1:0] didx;
  logic [CW-1:0] crc_din [NSIG];
  logic          crc_en  [NSIG];
  logic [CW-1:0] crc_sig [NSIG];
  logic [TOTAL-1:0] sig_flat;

  mbist_ctrl_port u_ctrl (
    .clk(clk), .rst_n(rst_n), .shift_en(ctl_shift_en), .sdi(ctl_sdi),
    .busy(busy), .launch(launch), .mode(mode)
  );

  mbist_seq #(.MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy),
    .launch(launch), .fin(fin), .wen(wen), .ren(ren), .addr(addr),
    .wdata(wdata), .didx(didx), .rd_vld(rd_vld)
  );

  mbist_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .wen(wen), .waddr(addr), .wdata(wdata),
    .ren(ren), .raddr(addr), .rdata(rdata)
  );

  always_comb begin
    for (int g = 0; g < NSIG; g++) crc_din[g] = '0;
    crc_din[0][AW-1:0]   = addr;
    crc_din[0][AW +: KW] = didx;
    crc_din[0][AW+KW]    = 1'b0;
    crc_din[1][AW-1:0]   = addr;
    crc_din[1][AW +: KW] = didx;
    crc_din[1][AW+KW]    = 1'b1;
    crc_din[2]           = CW'(rdata);
    crc_en[0] = wen;
    crc_en[1] = ren;
    crc_en[2] = rd_vld;
  end

  for (genvar g = 0; g < NSIG; g++) begin : g_crc
    mbist_crc #(.W(CW), .POLY(POLY[CW-1:0]), .SEED(SEED[CW-1:0])) u_crc (
      .clk(clk), .rst_n(rst_n), .seed_en(launch), .upd_en(crc_en[g]),
      .din(crc_din[g]), .sig(crc_sig[g])
    );
    assign sig_flat[g*CW +: CW] = crc_sig[g];
  end

  mbist_sig_out #(.TOTAL(TOTAL)) u_out (
    .clk(clk), .rst_n(rst_n), .load(fin), .clear(launch),
    .sig_flat(sig_flat), .ready(sig_ready), .valid(sig_valid), .bit_o(sig_bit)
  );

  // R8: signatures are never offered during a sweep
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sig_valid);
  // R1: quiet right after reset release
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !sig_valid));
endmodule

// File: tb/test_mbist_engine.sv
module test_mbist_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_en = 1'b0, sdi_a = 1'b0, sdi_b = 1'b0, start = 1'b0, ready = 1'b0;
  logic busy_a, busy_b, val_a, val_b, bit_a, bit_b;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mbist_engine i_mbist_engine (
    .clk(clk), .rst_n(rst_n), .ctl_shift_en(shift_en), .ctl_sdi(sdi_a),
    .start(start), .busy(busy_a), .sig_valid(val_a), .sig_ready(ready), .sig_bit(bit_a)
  );
  mbist_engine i_mbist_engine_b (
    .clk(clk), .rst_n(rst_n), .ctl_shift_en(shift_en), .ctl_sdi(sdi_b),
    .start(start), .busy(busy_b), .sig_valid(val_b), .sig_ready(ready), .sig_bit(bit_b)
  );

  typedef struct packed {
    logic [1:0] ma;
    logic [1:0] mb;
    logic [3:0] rdy;
  } vec_t;
  localparam vec_t VECS [4] = '{
    '{2'd0, 2'd3, 4'b1111},
    '{2'd1, 2'd2, 4'b0101},
    '{2'd2, 2'd1, 4'b1001},
    '{2'd3, 2'd0, 4'b0111}
  };

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(logic [15:0] c, logic [15:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 15; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [7:0] pat(logic [1:0] m, int a);
    logic [7:0] b;
    b = a[7:0];
    case (m)
      2'd0: return b;
      2'd1: return ~b;
      2'd2: return a[0] ? 8'hAA : 8'h55;
      default: return {b[3:0], b[7:4]};
    endcase
  endfunction

  function automatic logic [47:0] exp_sig(logic [1:0] m);
    logic [15:0] cw, cr, cd;
    cw = 16'hFFFF; cr = 16'hFFFF; cd = 16'hFFFF;
    for (int k = 0; k < 6; k++) begin
      for (int a = 0; a < (128 << k); a++) begin
        cw = crc_step(cw, {1'b0, 3'(k), 12'(a)});
        cr = crc_step(cr, {1'b1, 3'(k), 12'(a)});
        cd = crc_step(cd, {8'h00, pat(m, a)});
      end
    end
    return {cd, cr, cw};
  endfunction

  task automatic shift_modes(logic [1:0] ma, logic [1:0] mb);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      shift_en = 1'b1; sdi_a = ma[i]; sdi_b = mb[i];
    end
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  task automatic pulse_start(string tag);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy_a && busy_b, {tag, " R3 busy rises after start"}, {busy_a, busy_b}, 2'b11);
  endtask

  task automatic wait_run(bit disturb, string tag);
    int n = 1;
    bit mis_busy = 0, mis_val = 0;
    while (busy_a && n < 20000) begin
      if (busy_a !== busy_b) mis_busy = 1;
      if (val_a || val_b) mis_val = 1;
      if (disturb && n == 100) begin
        shift_en = 1'b1; sdi_a = 1'b0; sdi_b = 1'b1; start = 1'b1;
      end
      if (disturb && n == 103) begin
        shift_en = 1'b0; start = 1'b0;
      end
      @(negedge clk);
      if (busy_a) n++;
    end
    chk(n == 16130, {tag, " R3 busy length"}, n, 16130);
    chk(!mis_busy && !busy_b, {tag, " R9 lockstep busy"}, mis_busy, 0);
    chk(!mis_val, {tag, " R8 no bits while busy"}, mis_val, 0);
  endtask

  task automatic unload(logic [3:0] rdy, bit abort, logic [47:0] ea, logic [47:0] eb, string tag);
    logic [47:0] ga = '0, gb = '0;
    int idx = 0, guard = 0;
    bit pv = 0;
    logic pb = 1'b0;
    while (idx < 48 && guard < 1000) begin
      @(negedge clk);
      guard++;
      if (pv) chk(val_a && bit_a == pb, {tag, " R8 hold under back-pressure"}, {val_a, bit_a}, {1'b1, pb});
      if (abort && idx == 10) begin
        ready = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!val_a && !val_b && busy_a, {tag, " R10 unload abandoned"}, {val_a, val_b, busy_a}, 3'b001);
        return;
      end
      chk(val_a && val_b, {tag, " R8 valid during unload"}, {val_a, val_b}, 2'b11);
      ready = rdy[guard % 4];
      if (ready && val_a) begin
        ga[idx] = bit_a; gb[idx] = bit_b; idx++;
      end
      pv = val_a && !ready;
      pb = bit_a;
    end
    @(negedge clk);
    ready = 1'b0;
    chk(!val_a && !val_b, {tag, " R8 valid drops after 48 bits"}, {val_a, val_b}, 2'b00);
    chk(ga[15:0] == ea[15:0], {tag, " R4 write signature"}, ga[15:0], ea[15:0]);
    chk(ga[31:16] == ea[31:16], {tag, " R5 read signature"}, ga[31:16], ea[31:16]);
    chk(ga[47:32] == ea[47:32], {tag, " R6 R2 data signature"}, ga[47:32], ea[47:32]);
    chk(gb == eb, {tag, " R9 R2 second engine signatures"}, gb, eb);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_a && !val_a && !busy_b && !val_b, "R1 reset state", {busy_a, val_a, busy_b, val_b}, 4'b0000);

    for (int i = 0; i < 4; i++) begin
      shift_modes(VECS[i].ma, VECS[i].mb);
      pulse_start($sformatf("vec%0d", i));
      wait_run(1'b0, $sformatf("vec%0d", i));
      unload(VECS[i].rdy, 1'b0, exp_sig(VECS[i].ma), exp_sig(VECS[i].mb), $sformatf("vec%0d", i));
    end

    // R7: no new shift, shifting and start while busy must not alter mode or run
    pulse_start("dist");
    wait_run(1'b1, "dist R7");
    // R10: restart in the middle of an unload
    unload(4'b1111, 1'b1, '0, '0, "abort");
    wait_run(1'b0, "abort");
    unload(4'b1011, 1'b0, exp_sig(2'd3), exp_sig(2'd0), "R7 mode kept");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule